// File: doc/BRIEF.md
# Ping-Pong Writeback Address Sequencer

This block sequences the addresses of a two-slot frame buffer between a compositor that writes frames and a DMA engine that reads them back. The write and read sides each own a frame counter, and the parity of that counter selects one of two slots. An even count selects the side's base address. An odd count selects the base plus one frame size, where the frame size is height times width times bytes per pixel.

Writeback mode is a level request. When the request rises, the block latches both base addresses and the frame size, and it clears both counters. The read address is placed on its output one cycle before the compositor side is allowed to run. This ordering guarantees that the DMA engine never fetches through a stale pointer while the mode changes.

Each kick in writeback mode does three things. It produces the next write address, it advances the write counter, and it emits a start strobe. Each compositor-done event advances the read side, so the read slot trails the write slot by one frame. When the request falls, the block stops updating. It waits for the DMA engine to report done, and then it clears both addresses.

Top module: `wb_pp_seq`

## Requirements
- R1: After reset, wr_addr_o and rd_addr_o are 0 and start_o is 0.
- R2: The block samples wb_en_i high while idle at a clock edge. At that edge it latches wr_base_i, rd_base_i and the frame size, and clears both counters. From that edge, rd_addr_o equals the latched read base and wr_addr_o stays 0. The block ignores kick_req_i and comp_done_i in the cycle that follows this edge.
- R3: Once running, kick_req_i sampled high at an edge makes start_o high for exactly the following cycle. In that same cycle, wr_addr_o equals write base + (write counter odd ? frame size : 0), using the counter value before it increments. The first kick after enable therefore gives the write base itself.
- R4: Once running, comp_done_i sampled high at an edge sets rd_addr_o to read base + (read counter odd ? frame size : 0), using the counter value before it increments. The first done therefore gives the read base, and the second gives the read base plus the frame size.
- R5: The frame size is frame_h_i × frame_w_i × bpp. bpp is 2 when pix16_i = 1 and 3 when pix16_i = 0. The frame size is latched only at enable.
- R6: wb_en_i sampled low while running stops all address updates. Kicks and done events then produce no start_o and leave both addresses unchanged until dma_done_i is sampled high. At that edge both addresses become 0. While idle, kicks produce no start_o.
- R7: While running with wb_en_i held high, changes to the base, dimension and pixel-format inputs have no effect. The sequence continues from the latched values.
- R8: A kick and a done event in the same cycle each update their own side as if they had occurred alone.
- R9: Re-enabling after a disable restarts both counters at zero and uses the newly latched bases and frame size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_en_i | input | 1 | Writeback mode request (level) |
| wr_base_i | input | 32 | Base address of the write slots |
| rd_base_i | input | 32 | Base address of the read slots |
| frame_w_i | input | 16 | Frame width in pixels |
| frame_h_i | input | 16 | Frame height in lines |
| pix16_i | input | 1 | 1: 2 bytes per pixel, 0: 3 bytes per pixel |
| kick_req_i | input | 1 | Compositor start request, one cycle per frame |
| comp_done_i | input | 1 | Compositor finished a frame |
| dma_done_i | input | 1 | DMA engine finished a frame |
| wr_addr_o | output | 32 | Current compositor write address |
| rd_addr_o | output | 32 | Current DMA read address |
| start_o | output | 1 | Compositor start strobe |

## Verification
The assertions take for granted that the kick, compositor-done and DMA-done inputs are single-cycle events. They also assume the frame size fits in 32 bits, so that the two slot addresses of a side remain distinct and predictable. The stimulus changes inputs only on the falling clock edge and uses frame dimensions whose product stays well below 2^32. Disables are held until a DMA-done pulse has been delivered, so every drain phase completes before the next enable.

// File: rtl/wb_pp_pkg.sv
package wb_pp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_RUN   = 2'd2,
    ST_DRAIN = 2'd3
  } wb_state_e;

  function automatic logic [31:0] pp_offset(input logic odd, input logic [31:0] fsize);
    return odd ? fsize : 32'd0;
  endfunction
endpackage

// File: rtl/wb_pp_fsize.sv
module wb_pp_fsize #(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DIM_W-1:0]  w_i,
  input  logic [DIM_W-1:0]  h_i,
  input  logic              pix16_i,
  output logic [ADDR_W-1:0] fsize_o
);
  logic [ADDR_W-1:0] w_ext, h_ext, px, fsize_d;

  always_comb begin
    w_ext   = ADDR_W'(w_i);
    h_ext   = ADDR_W'(h_i);
    px      = w_ext * h_ext;
    // 2 or 3 bytes per pixel: shift, optional add
    fsize_d = pix16_i ? (px << 1) : ((px << 1) + px);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fsize_o <= '0;
    else if (load_i) fsize_o <= fsize_d;
  end
endmodule

// File: rtl/wb_pp_side.sv
module wb_pp_side #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8,
  parameter bit PRIME  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] fsize_i,
  output logic [ADDR_W-1:0] base_q_o,
  output logic [ADDR_W-1:0] addr_o
);
  import wb_pp_pkg::*;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q_o <= '0;
      addr_o   <= '0;
      cnt_q    <= '0;
    end else if (load_i) begin
      base_q_o <= base_i;
      cnt_q    <= '0;
      // read side points at slot 0 before the writer starts
      addr_o   <= PRIME ? base_i : '0;
    end else if (clr_i) begin
      addr_o   <= '0;
      cnt_q    <= '0;
    end else if (step_i) begin
      addr_o   <= base_q_o + ADDR_W'(pp_offset(cnt_q[0], 32'(fsize_i)));
      cnt_q    <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wb_pp_ctrl.sv
module wb_pp_ctrl (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wb_en_i,
  input  logic                 kick_req_i,
  input  logic                 comp_done_i,
  input  logic                 dma_done_i,
  output logic                 load_o,
  output logic                 clr_o,
  output logic                 wr_step_o,
  output logic                 rd_step_o,
  output logic                 start_o,
  output wb_pp_pkg::wb_state_e state_o
);
  import wb_pp_pkg::*;

  wb_state_e state_d;

  always_comb begin
    load_o    = (state_o == ST_IDLE) && wb_en_i;
    clr_o     = (state_o == ST_DRAIN) && dma_done_i;
    wr_step_o = (state_o == ST_RUN) && kick_req_i;
    rd_step_o = (state_o == ST_RUN) && comp_done_i;
    state_d   = state_o;
    unique case (state_o)
      ST_IDLE:  if (wb_en_i)    state_d = ST_ARM;
      ST_ARM:   state_d = wb_en_i ? ST_RUN : ST_DRAIN;
      ST_RUN:   if (!wb_en_i)   state_d = ST_DRAIN;
      ST_DRAIN: if (dma_done_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_IDLE;
      start_o <= 1'b0;
    end else begin
      state_o <= state_d;
      start_o <= wr_step_o;
    end
  end
endmodule

// File: rtl/wb_pp_seq.sv
module wb_pp_seq #(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wb_en_i,
  input  logic [ADDR_W-1:0] wr_base_i,
  input  logic [ADDR_W-1:0] rd_base_i,
  input  logic [DIM_W-1:0]  frame_w_i,
  input  logic [DIM_W-1:0]  frame_h_i,
  input  logic              pix16_i,
  input  logic              kick_req_i,
  input  logic              comp_done_i,
  input  logic              dma_done_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              start_o
);
  import wb_pp_pkg::*;

  localparam int N_SIDE = 2;  // 0: write, 1: read

  wb_state_e         state;
  logic              load, clr, wr_step, rd_step;
  logic [ADDR_W-1:0] fsize;
  logic [ADDR_W-1:0] side_base_in [N_SIDE];
  logic [ADDR_W-1:0] side_base_q  [N_SIDE];
  logic [ADDR_W-1:0] side_addr    [N_SIDE];
  logic              side_step    [N_SIDE];

  assign side_base_in[0] = wr_base_i;
  assign side_base_in[1] = rd_base_i;
  assign side_step[0]    = wr_step;
  assign side_step[1]    = rd_step;

  wb_pp_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wb_en_i     (wb_en_i),
    .kick_req_i  (kick_req_i),
    .comp_done_i (comp_done_i),
    .dma_done_i  (dma_done_i),
    .load_o      (load),
    .clr_o       (clr),
    .wr_step_o   (wr_step),
    .rd_step_o   (rd_step),
    .start_o     (start_o),
    .state_o     (state)
  );

  wb_pp_fsize #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_fsize (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .w_i     (frame_w_i),
    .h_i     (frame_h_i),
    .pix16_i (pix16_i),
    .fsize_o (fsize)
  );

  for (genvar g = 0; g < N_SIDE; g++) begin : g_side
    wb_pp_side #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PRIME(g == 1)) u_side (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load),
      .clr_i    (clr),
      .step_i   (side_step[g]),
      .base_i   (side_base_in[g]),
      .fsize_i  (fsize),
      .base_q_o (side_base_q[g]),
      .addr_o   (side_addr[g])
    );
  end

  assign wr_addr_o = side_addr[0];
  assign rd_addr_o = side_addr[1];
endmodule

// File: rtl/wb_pp_seq_chk.sv
module wb_pp_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 kick_req_i,
  input logic                 comp_done_i,
  input logic [ADDR_W-1:0]    wr_addr_o,
  input logic [ADDR_W-1:0]    rd_addr_o,
  input logic                 start_o,
  input wb_pp_pkg::wb_state_e state_i,
  input logic [ADDR_W-1:0]    wr_base_q_i,
  input logic [ADDR_W-1:0]    rd_base_q_i,
  input logic [ADDR_W-1:0]    fsize_i
);
  import wb_pp_pkg::*;

  // R1
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) |-> (wr_addr_o == '0 && rd_addr_o == '0 && !start_o));

  // R2
  arm_rd_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ARM) |-> (rd_addr_o == rd_base_q_i && wr_addr_o == '0));

  // R3
  start_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> ($past(kick_req_i) && $past(state_i) == ST_RUN));

  // R3
  start_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (wr_addr_o == wr_base_q_i || wr_addr_o == wr_base_q_i + fsize_i));

  // R6
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_addr_o != $past(wr_addr_o)) |->
      (($past(kick_req_i) && $past(state_i) == ST_RUN) || $past(state_i) == ST_DRAIN));

  // R4
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_o != $past(rd_addr_o)) |->
      (($past(comp_done_i) && $past(state_i) == ST_RUN) ||
       $past(state_i) == ST_IDLE || $past(state_i) == ST_DRAIN));
endmodule

bind wb_pp_seq wb_pp_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .kick_req_i  (kick_req_i),
  .comp_done_i (comp_done_i),
  .wr_addr_o   (wr_addr_o),
  .rd_addr_o   (rd_addr_o),
  .start_o     (start_o),
  .state_i     (state),
  .wr_base_q_i (side_base_q[0]),
  .rd_base_q_i (side_base_q[1]),
  .fsize_i     (fsize)
);

// File: tb/wb_pp_seq_tb.sv
module wb_pp_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 4;

  typedef struct packed {
    logic [15:0] w;
    logic [15:0] h;
    logic        pix16;
    logic [31:0] wb;
    logic [31:0] rb;
    logic [31:0] fs;
  } vec_t;

  // frame size column worked out by hand: h*w*(pix16 ? 2 : 3)
  localparam vec_t VECS [N_VEC] = '{
    '{16'd4,    16'd3,    1'b0, 32'h1000_0000, 32'h2000_0000, 32'd36},
    '{16'd640,  16'd480,  1'b1, 32'h3000_0100, 32'h4000_0200, 32'd614400},
    '{16'd1920, 16'd1080, 1'b0, 32'h0800_0000, 32'h0C00_0000, 32'd6220800},
    '{16'd1,    16'd1,    1'b1, 32'h0000_0040, 32'h0000_0080, 32'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wb_en = 1'b0;
  logic [31:0] wr_base = '0, rd_base = '0;
  logic [15:0] fw = '0, fh = '0;
  logic        pix16 = 1'b0;
  logic        kick = 1'b0, cdone = 1'b0, ddone = 1'b0;
  logic [31:0] wr_addr, rd_addr;
  logic        start;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wb_pp_seq u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wb_en_i     (wb_en),
    .wr_base_i   (wr_base),
    .rd_base_i   (rd_base),
    .frame_w_i   (fw),
    .frame_h_i   (fh),
    .pix16_i     (pix16),
    .kick_req_i  (kick),
    .comp_done_i (cdone),
    .dma_done_i  (ddone),
    .wr_addr_o   (wr_addr),
    .rd_addr_o   (rd_addr),
    .start_o     (start)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, one posedge applies, sample at next negedge
  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 wr_addr reset", wr_addr, 32'd0);
    chk("R1 rd_addr reset", rd_addr, 32'd0);
    chk("R1 start reset", {31'd0, start}, 32'd0);
    rst_n = 1'b1;
    step();
    kick = 1'b1;
    step();
    kick = 1'b0;
    chk("R6 idle kick no start", {31'd0, start}, 32'd0);
    chk("R6 idle wr_addr", wr_addr, 32'd0);

    for (int v = 0; v < N_VEC; v++) begin
      vec_t t = VECS[v];
      fw = t.w; fh = t.h; pix16 = t.pix16; wr_base = t.wb; rd_base = t.rb;
      wb_en = 1'b1;
      step();
      chk("R2 rd_addr primed at enable", rd_addr, t.rb);
      chk("R2 wr_addr zero at enable", wr_addr, 32'd0);
      kick = 1'b1; cdone = 1'b1;
      step();
      kick = 1'b0; cdone = 1'b0;
      chk("R2 kick ignored in arm cycle", {31'd0, start}, 32'd0);
      chk("R2 done ignored in arm cycle", rd_addr, t.rb);

      for (int k = 0; k < 4; k++) begin
        kick = 1'b1; cdone = 1'b1;
        step();
        kick = 1'b0; cdone = 1'b0;
        chk("R3 start pulse", {31'd0, start}, 32'd1);
        chk("R3 R5 R8 R9 write slot", wr_addr, t.wb + ((k % 2) ? t.fs : 32'd0));
        chk("R4 R5 R8 R9 read slot", rd_addr, t.rb + ((k % 2) ? t.fs : 32'd0));
        step();
        chk("R3 start single cycle", {31'd0, start}, 32'd0);
      end

      // R7: disturb configuration while running
      wr_base = 32'hDEAD_0000; rd_base = 32'hBEEF_0000; fw = 16'd7; fh = 16'd9; pix16 = ~t.pix16;
      for (int k = 0; k < 2; k++) begin
        kick = 1'b1;
        step();
        kick = 1'b0;
        chk("R7 latched write slot", wr_addr, t.wb + (k ? t.fs : 32'd0));
      end
      cdone = 1'b1;
      step();
      cdone = 1'b0;
      chk("R7 R4 latched read slot, done alone", rd_addr, t.rb);

      // R6: disable, drain
      wb_en = 1'b0;
      step();
      kick = 1'b1; cdone = 1'b1;
      step();
      kick = 1'b0; cdone = 1'b0;
      chk("R6 no start while draining", {31'd0, start}, 32'd0);
      chk("R6 wr_addr held while draining", wr_addr, t.wb + t.fs);
      chk("R6 rd_addr held while draining", rd_addr, t.rb);
      ddone = 1'b1;
      step();
      ddone = 1'b0;
      chk("R6 wr_addr cleared on dma done", wr_addr, 32'd0);
      chk("R6 rd_addr cleared on dma done", rd_addr, 32'd0);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule